// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-rank SDR SDRAM from power-on to normal operation. After reset is released it keeps the device deselected with the clock enabled for a fixed settling time. The time is counted in clock cycles and derived from the clock frequency parameter. The block then issues one NOP and one precharge of all banks. Eight auto-refresh commands follow, and after them a load of the mode register with a word supplied by the surrounding logic. Every command is spaced by its own parameterised gap, and only NOPs fill the cycles between commands.

Once the mode register has settled, `init_done` rises and stays high. A down-counter loaded from the refresh interval input then starts. Each time it runs out, the block issues an auto-refresh command on the same pins and reloads the counter. All pin outputs are registered, so the command, address, bank and `init_done` change together one cycle after the internal state moves.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset is released, the outputs show deselect (CS# high, RAS#/CAS#/WE# high, address 0) for exactly PAUSE_CYC = CLK_MHZ*PAUSE_US consecutive cycles, with no other command in between.
- R2: The cycle right after the pause carries a single NOP (CS# low, RAS#/CAS#/WE# high). Every later cycle that carries no other command is also a NOP with address and bank 0.
- R3: The cycle after that first NOP carries a precharge-all command (CS# low, RAS# low, CAS# high, WE# low), with address bit 10 high, all other address bits low and bank 0.
- R4: The first auto-refresh command appears exactly T_RP cycles after the precharge.
- R5: Exactly eight auto-refresh commands (CS# low, RAS# low, CAS# low, WE# high, address 0) are issued, with consecutive ones T_RFC cycles apart.
- R6: Exactly T_RFC cycles after the eighth refresh, a load-mode command (CS#, RAS#, CAS#, WE# all low) appears, with the address equal to `mode_word` and bank 0.
- R7: `init_done` is low until exactly T_MRD cycles after the load-mode command, then stays high until the next reset.
- R8: When the interval input is I, the first periodic auto-refresh falls on the I-th cycle with `init_done` high (the first such cycle counts as 1), and later ones follow every I cycles. An interval of 1 refreshes on every such cycle.
- R9: A synchronous active-low reset, applied at any point in the sequence, clears `init_done` and forces deselect within one clock edge. After release the whole sequence restarts from the pause.
- R10: CKE is high on every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_word | input | ADDR_W | Value placed on the address lines by the load-mode command |
| ref_interval | input | REF_W | Cycles between periodic refreshes in normal mode |
| sd_cke | output | 1 | Clock enable to the device |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address lines |
| sd_ba | output | BA_W | Bank select lines |
| init_done | output | 1 | High once the device is ready for normal use |

## Verification
Each run compares every output cycle against a command schedule computed from the parameters. The bench sweeps several refresh intervals, including 1 and a prime value, so that an off-by-one in the reload shows up as drift across many periods. Several mode words with distinct bit patterns separate a correct mode load from stuck or shifted address lines. Resets applied in the middle of the refresh burst and again in normal mode show that the restart clears `init_done`, does not carry the refresh count over, and replays the full pause.

// File: rtl/sdram_init_pkg.sv
// Shared types for the SDRAM power-up sequencer.
// Assumes single-rank SDR SDRAM command pins (CS#, RAS#, CAS#, WE#).
package sdram_init_pkg;

    typedef enum logic [2:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_PRECH,
        CMD_AREF,
        CMD_LMODE
    } sdi_cmd_e;

    typedef enum logic [3:0] {
        ST_PAUSE,
        ST_NOP,
        ST_PRECH,
        ST_GAP_RP,
        ST_AREF,
        ST_GAP_RFC,
        ST_LMODE,
        ST_GAP_MRD,
        ST_RUN
    } sdi_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdi_pins_t;

    // Map an abstract command to its four control-pin levels.
    function automatic sdi_pins_t sdi_encode(input sdi_cmd_e c);
        sdi_pins_t p;
        unique case (c)
            CMD_NOP:   p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            CMD_PRECH: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_AREF:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_LMODE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            default:   p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sdram_gap_counter.sv
// Loadable down-counter that times the pause and the command gaps.
// Assumes the load value fits CNT_W. Holds at zero until reloaded.
// Resets to RST_VAL so that the pause is timed without an explicit load.
module sdram_gap_counter #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    assign zero = (cnt_q == '0);

    // Reload on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= CNT_W'(RST_VAL);
        else if (load)    cnt_q <= load_val;
        else if (!zero)   cnt_q <= cnt_q - 1'b1;
    end

    // A load is only issued by the sequencer once the running gap has expired.
    a_r4_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> zero);
endmodule

// File: rtl/sdram_refresh_timer.sv
// Periodic refresh down-counter used in normal mode.
// While disabled it keeps itself primed with interval-1, so the first
// request falls on the interval-th enabled cycle. An interval of 0 wraps
// to the full counter range.
module sdram_refresh_timer #(
    parameter int REF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [REF_W-1:0] interval,
    output logic             fire
);
    logic [REF_W-1:0] cnt_q;
    logic [REF_W-1:0] reload;

    assign reload = interval - {{(REF_W-1){1'b0}}, 1'b1};
    assign fire   = en && (cnt_q == '0);

    // Prime while idle, reload on expiry, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!en || fire)  cnt_q <= reload;
        else                   cnt_q <= cnt_q - 1'b1;
    end

    a_r8_reload_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cnt_q == $past(interval) - {{(REF_W-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/sdram_init_fsm.sv
// Power-up state machine. Steps through pause, NOP, precharge-all, the
// refresh burst and the mode load, then holds in normal mode, where it
// forwards refresh timer requests as auto-refresh commands.
// Emits an unregistered command token; the pin stage registers it.
// Assumes T_RP, T_RFC and T_MRD are at least 2 and PAUSE_CYC is at least 2.
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int PAUSE_CYC = 20000,
    parameter int T_RP      = 3,
    parameter int T_RFC     = 7,
    parameter int T_MRD     = 2,
    parameter int NUM_REF   = 8,
    parameter int ADDR_W    = 13,
    parameter int BA_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mode_word,
    input  logic              ref_fire,
    output sdi_cmd_e          tok_cmd,
    output logic [ADDR_W-1:0] tok_addr,
    output logic [BA_W-1:0]   tok_ba,
    output logic              run
);
    localparam int MAX_GAP = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                            : ((T_RP > T_MRD) ? T_RP : T_MRD);
    localparam int MAX_CNT = (PAUSE_CYC > MAX_GAP) ? PAUSE_CYC : MAX_GAP;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam int RC_W    = $clog2(NUM_REF + 1);
    localparam int A10     = 10;

    sdi_state_e       state_q, state_d;
    logic [RC_W-1:0]  refs_q;
    logic             gap_load;
    logic [CNT_W-1:0] gap_val;
    logic             gap_zero;

    sdram_gap_counter #(.CNT_W(CNT_W), .RST_VAL(PAUSE_CYC - 1)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .zero     (gap_zero)
    );

    // Next-state and gap-load selection.
    always_comb begin
        state_d  = state_q;
        gap_load = 1'b0;
        gap_val  = '0;
        unique case (state_q)
            ST_PAUSE:   if (gap_zero) state_d = ST_NOP;
            ST_NOP:     state_d = ST_PRECH;
            ST_PRECH: begin
                state_d  = ST_GAP_RP;
                gap_load = 1'b1;
                gap_val  = CNT_W'(T_RP - 2);
            end
            ST_GAP_RP:  if (gap_zero) state_d = ST_AREF;
            ST_AREF: begin
                state_d  = ST_GAP_RFC;
                gap_load = 1'b1;
                gap_val  = CNT_W'(T_RFC - 2);
            end
            ST_GAP_RFC: if (gap_zero)
                            state_d = (refs_q == RC_W'(NUM_REF)) ? ST_LMODE : ST_AREF;
            ST_LMODE: begin
                state_d  = ST_GAP_MRD;
                gap_load = 1'b1;
                gap_val  = CNT_W'(T_MRD - 2);
            end
            ST_GAP_MRD: if (gap_zero) state_d = ST_RUN;
            ST_RUN:     state_d = ST_RUN;
            default:    state_d = ST_PAUSE;
        endcase
    end

    // State register and refresh-burst counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PAUSE;
            refs_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_AREF) refs_q <= refs_q + 1'b1;
        end
    end

    // Command token for the current cycle.
    always_comb begin
        tok_addr = '0;
        tok_ba   = '0;
        unique case (state_q)
            ST_PAUSE: tok_cmd = CMD_DESEL;
            ST_PRECH: begin
                tok_cmd       = CMD_PRECH;
                tok_addr[A10] = 1'b1;
            end
            ST_AREF:  tok_cmd = CMD_AREF;
            ST_LMODE: begin
                tok_cmd  = CMD_LMODE;
                tok_addr = mode_word;
            end
            ST_RUN:   tok_cmd = ref_fire ? CMD_AREF : CMD_NOP;
            default:  tok_cmd = CMD_NOP;
        endcase
    end

    assign run = (state_q == ST_RUN);

    a_r3_prech_after_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NOP) |=> (state_q == ST_PRECH));
    a_r5_burst_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        refs_q <= RC_W'(NUM_REF));
    a_r6_lmode_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LMODE) |-> (refs_q == RC_W'(NUM_REF)));
    a_r7_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (state_q == ST_RUN));
endmodule

// File: rtl/sdram_pin_stage.sv
// Output register stage. Encodes the command token onto the control pins
// and registers address, bank, CKE and the done flag with the same latency,
// so all pins change on one edge. Resets to deselect with CKE high.
module sdram_pin_stage
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sdi_cmd_e          tok_cmd,
    input  logic [ADDR_W-1:0] tok_addr,
    input  logic [BA_W-1:0]   tok_ba,
    input  logic              run,
    output logic              cke,
    output sdi_pins_t         pins,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              done
);
    // Register every pin on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke  <= 1'b1;
            pins <= sdi_encode(CMD_DESEL);
            addr <= '0;
            ba   <= '0;
            done <= 1'b0;
        end else begin
            cke  <= 1'b1;
            pins <= sdi_encode(tok_cmd);
            addr <= tok_addr;
            ba   <= tok_ba;
            done <= run;
        end
    end

    a_r2_select_implies_done_or_init: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pins.cs_n) |-> (pins.we_n && (addr == '0)));
endmodule

// File: rtl/sdram_init_seq.sv
// Top of the SDRAM power-up sequencer. Connects the state machine, the
// refresh timer and the registered pin stage.
// Assumes ADDR_W > 10 so that the all-bank precharge bit exists.
module sdram_init_seq #(
    parameter int CLK_MHZ  = 100,
    parameter int PAUSE_US = 200,
    parameter int T_RP     = 3,
    parameter int T_RFC    = 7,
    parameter int T_MRD    = 2,
    parameter int ADDR_W   = 13,
    parameter int BA_W     = 2,
    parameter int REF_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mode_word,
    input  logic [REF_W-1:0]  ref_interval,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic              init_done
);
    import sdram_init_pkg::*;

    localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
    localparam int NUM_REF   = 8;

    sdi_cmd_e          tok_cmd;
    logic [ADDR_W-1:0] tok_addr;
    logic [BA_W-1:0]   tok_ba;
    logic              run;
    logic              ref_fire;
    sdi_pins_t         pins;

    sdram_init_fsm #(
        .PAUSE_CYC (PAUSE_CYC),
        .T_RP      (T_RP),
        .T_RFC     (T_RFC),
        .T_MRD     (T_MRD),
        .NUM_REF   (NUM_REF),
        .ADDR_W    (ADDR_W),
        .BA_W      (BA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_word (mode_word),
        .ref_fire  (ref_fire),
        .tok_cmd   (tok_cmd),
        .tok_addr  (tok_addr),
        .tok_ba    (tok_ba),
        .run       (run)
    );

    sdram_refresh_timer #(.REF_W(REF_W)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (run),
        .interval (ref_interval),
        .fire     (ref_fire)
    );

    sdram_pin_stage #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .tok_cmd  (tok_cmd),
        .tok_addr (tok_addr),
        .tok_ba   (tok_ba),
        .run      (run),
        .cke      (sd_cke),
        .pins     (pins),
        .addr     (sd_addr),
        .ba       (sd_ba),
        .done     (init_done)
    );

    assign sd_cs_n  = pins.cs_n;
    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;

    a_r6_mode_on_lmode: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n)
            |-> (sd_addr == $past(mode_word) && sd_ba == '0));
    a_r7_done_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
endmodule

// File: tb/sdram_init_seq_test.sv
// Cycle-exact bench: every output cycle is compared with a schedule
// computed from the parameters.
module sdram_init_seq_test;
    localparam int CLK_MHZ  = 1;
    localparam int PAUSE_US = 200;
    localparam int T_RP     = 3;
    localparam int T_RFC    = 5;
    localparam int T_MRD    = 2;
    localparam int ADDR_W   = 13;
    localparam int BA_W     = 2;
    localparam int REF_W    = 16;
    localparam int P        = CLK_MHZ * PAUSE_US;
    localparam int S_PRE    = P + 1;
    localparam int S_R0     = S_PRE + T_RP;
    localparam int S_LM     = S_R0 + 8 * T_RFC;
    localparam int S_DONE   = S_LM + T_MRD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] mode_word = '0;
    logic [REF_W-1:0]  ref_interval = 16'd10;
    logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
    logic [ADDR_W-1:0] sd_addr;
    logic [BA_W-1:0]   sd_ba;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #5 clk = ~clk;

    sdram_init_seq #(
        .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .T_RP(T_RP), .T_RFC(T_RFC),
        .T_MRD(T_MRD), .ADDR_W(ADDR_W), .BA_W(BA_W), .REF_W(REF_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .ref_interval(ref_interval),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba), .init_done(init_done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            n_tests = n_tests + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests = n_tests + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Encodings (R1/R2/R3/R5/R6): {cs,ras,cas,we}
    function automatic logic [3:0] enc(input int k);
        case (k)
            1: return 4'b0111;  // NOP
            2: return 4'b0010;  // precharge
            3: return 4'b0001;  // auto-refresh
            4: return 4'b0000;  // load mode
            default: return 4'b1111;
        endcase
    endfunction

    // Expected command kind at sample s; tag names the rule it comes from.
    function automatic int exp_kind(input int s, input int iv, output string tag);
        tag = "R2";
        if (s < P) begin tag = "R1"; return 0; end
        if (s == P) return 1;
        if (s == S_PRE) begin tag = "R3"; return 2; end
        if (s == S_R0) begin tag = "R4"; return 3; end
        if (s > S_R0 && s < S_LM && ((s - S_R0) % T_RFC) == 0) begin tag = "R5"; return 3; end
        if (s == S_LM) begin tag = "R6"; return 4; end
        if (s >= S_DONE && ((s - S_DONE + 1) % iv) == 0) begin tag = "R8"; return 3; end
        return 1;
    endfunction

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R9: reset forces deselect and clears init_done
        chk(init_done == 1'b0, "R9 done cleared", 32'(init_done), 32'd0);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b1111, "R9 deselect",
            32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'hf);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_seq(input logic [ADDR_W-1:0] mw, input int iv, input int nsamp);
        string tag;
        mode_word    = mw;
        ref_interval = REF_W'(iv);
        apply_reset();
        for (int s = 0; s < nsamp; s++) begin
            int k;
            logic [ADDR_W-1:0] ea;
            @(posedge clk);
            @(negedge clk);
            k = exp_kind(s, iv, tag);
            ea = (k == 2) ? ADDR_W'(1 << 10) : (k == 4) ? mw : '0;
            chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == enc(k), tag,
                32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'(enc(k)));
            chk(sd_addr == ea && sd_ba == '0, tag, 32'({sd_ba, sd_addr}), 32'(ea));
            chk(init_done == (s >= S_DONE), "R7", 32'(init_done), 32'(s >= S_DONE));
            chk(sd_cke == 1'b1, "R10", 32'(sd_cke), 32'd1);
        end
    endtask

    initial begin
        run_seq(13'h0033, 7, S_DONE + 40);
        run_seq(13'h1AA5, 1, S_DONE + 10);
        run_seq(13'h0FFF, 13, S_DONE + 60);
        // R9: interrupt during the refresh burst, then during normal mode
        run_seq(13'h0555, 9, S_R0 + 12);
        run_seq(13'h1E01, 9, S_DONE + 25);
        run_seq(13'h0AAA, 20, S_DONE + 70);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule